// File: doc/BRIEF.md
# Transition-Signalled Single-Slot Queue Stage

This block is a clocked, one-entry queue stage between a producer and a consumer. Both sides use two-phase signalling: a request is an edge on a request line, and it is answered by an edge on the matching acknowledge line. A side has a request outstanding whenever its request and acknowledge levels differ. Inside, the stage holds one data register and a full flag. From the external edge events it makes level-style control: a load strobe that fills the register and a drain event that empties it.

A producer puts a word on `in_data` and toggles `in_req`. When the slot is empty, the stage captures the word and toggles `in_ack` one cycle later. It then offers the word by toggling `out_req`. When the consumer toggles `out_ack` back to match, the slot empties and the next word can enter. A synchronous `init` input holds the stage empty with both driven handshake lines low, so that both neighbours start at matching levels.

Top module: `tq_stage`

## Requirements
- R1: While `init` is high, `in_ack` and `out_req` read 0 and the slot is empty. After `init` falls, a stage with no input request outstanding issues no output request.
- R2: When an input request is outstanding (`in_req` != `in_ack`) and the slot is empty, the stage captures `in_data` on that clock edge. From the next cycle, `out_data` shows the captured word.
- R3: `in_ack` toggles exactly once per captured word, in the cycle after the load, at the same edge that captures the data.
- R4: While the slot is full, `in_ack` does not change, even when a new input request is outstanding.
- R5: The cycle after the full flag rises, `out_req` toggles once, which makes an output request outstanding.
- R6: When the slot is full and its output request has been answered (`out_ack` == `out_req`), the slot empties on the next edge. A waiting input request is then accepted on the edge after that.
- R7: While the slot is empty, `out_req` does not change. Each accepted word produces exactly one `out_req` toggle.
- R8: While an output request is outstanding, `out_data` stays stable.
- R9: Words reach the consumer in the order they were offered, with none lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init | input | 1 | Synchronous initialisation; empties the stage and drives handshake outputs low |
| in_req | input | 1 | Producer request; each edge offers a word |
| in_ack | output | 1 | Producer acknowledge; toggles once per accepted word |
| in_data | input | DATA_W | Word offered by the producer |
| out_req | output | 1 | Consumer request; toggles once per word held |
| out_ack | input | 1 | Consumer acknowledge; an edge that matches `out_req` frees the slot |
| out_data | output | DATA_W | Word held in the slot |

## Verification
The stage is run with three consumer behaviours. A consumer that answers at once checks the shortest load, offer and drain loop and its cycle counts. A consumer that waits several cycles keeps the slot full while the producer has already raised a new request, so the holding of `in_ack` and the stability of `out_data` can be seen. A consumer with pseudo-random delays mixes both cases and exposes ordering, loss or duplicated requests. A cycle-level reference model predicts `in_ack`, `out_req` and `out_data` every cycle, and the consumer also compares each word it receives against the order in which the producer sent them.

// File: rtl/tq_pkg.sv
package tq_pkg;
  // A two-phase side has a request outstanding when the levels differ.
  function automatic logic side_pending(input logic req_lvl, input logic ack_lvl);
    return req_lvl ^ ack_lvl;
  endfunction

  // An output request counts as answered once the levels match again.
  function automatic logic side_answered(input logic req_lvl, input logic ack_lvl);
    return ~(req_lvl ^ ack_lvl);
  endfunction
endpackage

// File: rtl/tq_in_ctl.sv
module tq_in_ctl
  import tq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  input  logic in_req,
  input  logic slot_full,
  output logic in_ack,
  output logic load_stb
);
  logic ack_q;

  assign load_stb = !init && side_pending(in_req, ack_q) && !slot_full;
  assign in_ack   = ack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ack_q <= 1'b0;
    else if (init)     ack_q <= 1'b0;
    else if (load_stb) ack_q <= ~ack_q;
  end

  // R4: a full slot freezes the producer acknowledge
  p_ack_hold_r4: assert property (@(posedge clk) disable iff (!rst_n || init)
    slot_full |=> $stable(in_ack));
endmodule

// File: rtl/tq_slot.sv
module tq_slot #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              load_stb,
  input  logic              drain_evt,
  input  logic [DATA_W-1:0] in_data,
  output logic              slot_full,
  output logic [DATA_W-1:0] slot_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         slot_full <= 1'b0;
    else if (init)      slot_full <= 1'b0;
    else if (load_stb)  slot_full <= 1'b1;
    else if (drain_evt) slot_full <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        slot_data <= '0;
    else if (load_stb) slot_data <= in_data;
  end

  // R2: a load makes the captured word visible on the next cycle
  p_load_capture_r2: assert property (@(posedge clk) disable iff (!rst_n || init)
    load_stb |=> (slot_full && slot_data == $past(in_data)));
endmodule

// File: rtl/tq_out_ctl.sv
module tq_out_ctl
  import tq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  input  logic slot_full,
  input  logic out_ack,
  output logic out_req,
  output logic issue_evt,
  output logic drain_evt
);
  logic req_q;
  logic sent_q;

  assign issue_evt = !init && slot_full && !sent_q;
  assign drain_evt = !init && slot_full && sent_q && side_answered(req_q, out_ack);
  assign out_req   = req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      sent_q <= 1'b0;
    end else if (init) begin
      req_q  <= 1'b0;
      sent_q <= 1'b0;
    end else if (issue_evt) begin
      req_q  <= ~req_q;
      sent_q <= 1'b1;
    end else if (drain_evt) begin
      sent_q <= 1'b0;
    end
  end

  // R7: an empty slot never issues a request
  p_empty_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n || init)
    !slot_full |=> $stable(out_req));
  // R5: the rise of the full flag is followed by a single request toggle
  p_req_after_full_r5: assert property (@(posedge clk) disable iff (!rst_n || init)
    $rose(slot_full) |=> (out_req != $past(out_req)));
endmodule

// File: rtl/tq_stage.sv
module tq_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init,
  input  logic              in_req,
  output logic              in_ack,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_req,
  input  logic              out_ack,
  output logic [DATA_W-1:0] out_data
);
  logic load_stb;
  logic drain_evt;
  logic issue_evt;
  logic slot_full;

  tq_in_ctl u_in (
    .clk(clk), .rst_n(rst_n), .init(init), .in_req(in_req),
    .slot_full(slot_full), .in_ack(in_ack), .load_stb(load_stb)
  );

  tq_slot #(.DATA_W(DATA_W)) u_slot (
    .clk(clk), .rst_n(rst_n), .init(init), .load_stb(load_stb),
    .drain_evt(drain_evt), .in_data(in_data),
    .slot_full(slot_full), .slot_data(out_data)
  );

  tq_out_ctl u_out (
    .clk(clk), .rst_n(rst_n), .init(init), .slot_full(slot_full),
    .out_ack(out_ack), .out_req(out_req),
    .issue_evt(issue_evt), .drain_evt(drain_evt)
  );

  // R1: initialisation drives both handshake outputs low and empties the slot
  p_init_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (!in_ack && !out_req && !slot_full));
  // R3: a load toggles the producer acknowledge on the same edge
  p_ack_on_load_r3: assert property (@(posedge clk) disable iff (!rst_n || init)
    load_stb |=> (in_ack != $past(in_ack)));
  // R6: an answered output request frees the slot
  p_drain_empties_r6: assert property (@(posedge clk) disable iff (!rst_n || init)
    drain_evt |=> !slot_full);
  // R8: the offered word holds while the consumer has not answered
  p_data_hold_r8: assert property (@(posedge clk) disable iff (!rst_n || init)
    (out_req != out_ack) |=> $stable(out_data));
  // R7: the output side issues at most one request per fill
  p_single_issue_r7: assert property (@(posedge clk) disable iff (!rst_n || init)
    issue_evt |=> !issue_evt);
endmodule

// File: tb/tq_stage_bench.sv
module tq_stage_bench;
  localparam int W = 8;
  localparam int N_PER_PHASE = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init = 1'b1;
  logic in_req = 1'b0;
  logic out_ack = 1'b0;
  logic [W-1:0] in_data = '0;
  logic in_ack;
  logic out_req;
  logic [W-1:0] out_data;

  int tests = 0;
  int fails = 0;
  int cycles = 0;
  int delay_mode = 0;
  int received = 0;
  int lfsr = 32'h1d;

  // behavioural reference state
  bit m_full = 0, m_sent = 0, m_ack = 0, m_req = 0;
  logic [W-1:0] m_data = '0;
  logic [W-1:0] exp_q[$];

  always #2.5 clk = ~clk;

  tq_stage #(.DATA_W(W)) u_tq_stage (
    .clk(clk), .rst_n(rst_n), .init(init), .in_req(in_req), .in_ack(in_ack),
    .in_data(in_data), .out_req(out_req), .out_ack(out_ack), .out_data(out_data)
  );

  // Reference model: advances on each edge from the stable bench inputs.
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rst_n || init) begin
      m_full <= 0; m_sent <= 0; m_ack <= 0; m_req <= 0;
      if (!rst_n) m_data <= '0;
    end else if (!m_full && (in_req != m_ack)) begin
      m_full <= 1; m_data <= in_data; m_ack <= ~m_ack;
    end else if (m_full && !m_sent) begin
      m_req <= ~m_req; m_sent <= 1;
    end else if (m_full && m_sent && (out_ack == m_req)) begin
      m_full <= 0; m_sent <= 0;
    end
  end

  // Compare every cycle, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      tests++;
      if (in_ack !== m_ack) begin
        fails++;
        $display("FAIL R3 R4 R6 in_ack: got %0b expected %0b", in_ack, m_ack);
      end
      tests++;
      if (out_req !== m_req) begin
        fails++;
        $display("FAIL R5 R7 out_req: got %0b expected %0b", out_req, m_req);
      end
      tests++;
      if (out_data !== m_data) begin
        fails++;
        $display("FAIL R2 R8 out_data: got %0h expected %0h", out_data, m_data);
      end
    end
  end

  task automatic consumer_wait(input int mode);
    int d;
    if (mode == 0) d = 0;
    else if (mode == 1) d = 6;
    else begin
      lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hb4 : 0);
      d = lfsr % 5;
    end
    repeat (d) @(negedge clk);
  endtask

  initial begin : consumer
    forever begin
      @(negedge clk);
      if (rst_n && !init && (out_req !== out_ack)) begin
        logic [W-1:0] want;
        tests++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R7 R9 extra request: got %0h expected none", out_data);
        end else begin
          want = exp_q.pop_front();
          if (out_data !== want) begin
            fails++;
            $display("FAIL R9 word order: got %0h expected %0h", out_data, want);
          end
        end
        consumer_wait(delay_mode);
        out_ack = out_req;
        received++;
      end
    end
  end

  task automatic produce(input int count, input int gap);
    for (int i = 0; i < count; i++) begin
      while (in_req !== in_ack) @(negedge clk);
      in_data = W'(i * 37 + gap * 11 + 5);
      exp_q.push_back(in_data);
      in_req = ~in_req;
      repeat (gap + 1) @(negedge clk);
    end
  endtask

  initial begin : main
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: outputs held low during init
    tests++;
    if (in_ack !== 1'b0 || out_req !== 1'b0) begin
      fails++;
      $display("FAIL R1 init outputs: got %0b%0b expected 00", in_ack, out_req);
    end
    init = 1'b0;
    repeat (4) @(negedge clk);
    // R1: no request issued with nothing offered
    tests++;
    if (out_req !== 1'b0) begin
      fails++;
      $display("FAIL R1 idle request: got %0b expected 0", out_req);
    end
    // R2 R3 R5: fast consumer, back-to-back producer
    delay_mode = 0;
    produce(N_PER_PHASE, 0);
    // R4 R6 R8: slow consumer keeps the slot full
    delay_mode = 1;
    produce(N_PER_PHASE, 0);
    // R9: irregular consumer and producer gaps
    delay_mode = 2;
    produce(N_PER_PHASE, 2);
    while (received < 3 * N_PER_PHASE) @(negedge clk);
    repeat (10) @(negedge clk);
    // R9: every word delivered
    tests++;
    if (received != 3 * N_PER_PHASE || exp_q.size() != 0) begin
      fails++;
      $display("FAIL R9 delivery count: got %0d expected %0d", received, 3 * N_PER_PHASE);
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : watchdog
    while (cycles < 100000) @(negedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: got %0d cycles expected completion", cycles);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule